// File: doc/BRIEF.md
# Packet-Atomic Readback FIFO

This block buffers readback data on its way to a bus. An internal producer delivers data in fixed packets of four 32-bit words, and a bus-side reader drains the buffer one word per read request. The storage holds 2048 words. A packet goes in whole or not at all. If the buffer lacks room for every word of the packet, the packet is thrown away and a sticky drop flag records the loss.

The producer side is a valid/ready stream. The producer places all four words on `pkt_data` (word 0 in bits 31:0, word 1 in bits 63:32, and so on) and raises `pkt_valid`. It must hold `pkt_valid` and `pkt_data` steady until a clock edge at which `pkt_ready` is high. That edge consumes the packet, whether it is stored or dropped. A stored packet is written one word per cycle in word-index order, and `pkt_ready` stays low for the four write cycles. A dropped packet leaves `pkt_ready` high.

The read side has no back-pressure. Each `rd_en` cycle is answered one cycle later with `rd_valid` and a word on `rd_data`. A read of an empty buffer answers zero and changes nothing. A write aimed at the read window (`bus_wr_en`) is ignored and only raises a sticky error flag. Both flags are cleared by write-one-to-clear pulses.

Top module: `rbf_top`

## Requirements
- R1: After reset the buffer is empty, `drop_err` and `wr_err` are 0, `rd_valid` is 0 and `pkt_ready` is 1.
- R2: A packet offered while at least four entries are free is accepted at the edge where `pkt_valid` and `pkt_ready` are both high. `pkt_ready` is then low for exactly the four following cycles, and the words are stored in index order, word 0 first.
- R3: Every cycle with `rd_en` high is answered in the next cycle with `rd_valid` high and the oldest stored word on `rd_data`. `rd_valid` is low in any cycle that does not follow a read request.
- R4: A read while the buffer is empty answers with `rd_valid` high and `rd_data` equal to 0, and leaves the contents and their order unchanged.
- R5: A packet offered while fewer than four entries are free is discarded whole. None of its words are stored, `pkt_ready` stays high, and `drop_err` is 1 from the next cycle.
- R6: Exactly four free entries is enough room, so the buffer can be filled to all 2048 entries, and all 2048 words read back in order.
- R7: `drop_err` stays set until a cycle with `clr_drop` high clears it. If a drop and `clr_drop` occur in the same cycle, the flag is set.
- R8: A `bus_wr_en` pulse changes no stored data and sets `wr_err` from the next cycle. `wr_err` stays set until `clr_wr_err` clears it.
- R9: Reads during the four write cycles of a packet pop correct data, and nothing is lost or duplicated when a read and a word write share a cycle.
- R10: The fill level never exceeds 2048 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Producer offers a packet |
| pkt_ready | output | 1 | Block can take a packet this cycle |
| pkt_data | input | 128 | Four packet words, word 0 in bits 31:0 |
| rd_en | input | 1 | Bus read request, pops one word |
| rd_valid | output | 1 | Read answer valid (one cycle after `rd_en`) |
| rd_data | output | 32 | Read answer, 0 when the buffer was empty |
| bus_wr_en | input | 1 | Bus write aimed at the read window (ignored) |
| clr_drop | input | 1 | Write-one-to-clear for `drop_err` |
| clr_wr_err | input | 1 | Write-one-to-clear for `wr_err` |
| drop_err | output | 1 | Sticky: a packet was discarded for lack of room |
| wr_err | output | 1 | Sticky: a write hit the read window |

## Verification
The hardest case to reach is a buffer with one to three free entries. Filling the buffer needs 512 accepted packets, and the buffer must then be drained to an exact partial level. The stimulus fills the buffer to the last entry and offers one more packet to force a drop. It then pops one word and offers a packet that must also be dropped. After three more pops it offers a packet at exactly four free entries, which must be accepted. Throughout, the bench keeps a queue of the words it expects and drains the whole buffer against that queue, so any lost, partial or reordered packet shows up.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  typedef enum logic [0:0] {
    LD_IDLE = 1'b0,
    LD_FILL = 1'b1
  } ld_state_e;

endpackage

// File: rtl/rbf_sticky.sv
module rbf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/rbf_storage.sv
module rbf_storage #(
  parameter int DEPTH = 2048,
  parameter int DW    = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_en_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [LVL_W-1:0] level_o
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             pop;

  // A pop only happens when something is stored.
  assign pop = rd_en_i && (level_q != '0);

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[wr_ptr_q] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (we_i) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
      if (pop) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
      level_q <= level_q + LVL_W'(we_i) - LVL_W'(pop);
    end
  end

  // Read answer: one cycle after the request, zero on an empty read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        rd_data_o <= pop ? mem[rd_ptr_q] : '0;
      end
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/rbf_loader.sv
module rbf_loader
  import rbf_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int DW        = 32,
  parameter int PKT_WORDS = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(PKT_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_valid_i,
  output logic                    pkt_ready_o,
  input  logic [PKT_WORDS*DW-1:0] pkt_data_i,
  input  logic [LVL_W-1:0]        level_i,
  output logic                    we_o,
  output logic [DW-1:0]           wdata_o,
  output logic                    drop_o
);

  localparam logic [LVL_W-1:0] ROOM_LIM = LVL_W'(DEPTH - PKT_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

  ld_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    shadow_q [PKT_WORDS];
  logic             offer;
  logic             fits;
  logic             accept;

  assign pkt_ready_o = (state_q == LD_IDLE);
  assign offer       = pkt_valid_i && pkt_ready_o;
  // Room for the whole packet: free = DEPTH - level >= PKT_WORDS.
  assign fits        = (level_i <= ROOM_LIM);
  assign accept      = offer && fits;
  assign drop_o      = offer && !fits;

  for (genvar w = 0; w < PKT_WORDS; w++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (accept) begin
        shadow_q[w] <= pkt_data_i[w*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        LD_IDLE: begin
          if (accept) begin
            state_q <= LD_FILL;
            idx_q   <= '0;
          end
        end
        LD_FILL: begin
          if (idx_q == LAST_IDX) begin
            state_q <= LD_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign we_o    = (state_q == LD_FILL);
  assign wdata_o = shadow_q[idx_q];

endmodule

// File: rtl/rbf_top.sv
module rbf_top #(
  parameter int DEPTH     = 2048,
  parameter int DW        = 32,
  parameter int PKT_WORDS = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_valid,
  output logic                    pkt_ready,
  input  logic [PKT_WORDS*DW-1:0] pkt_data,
  input  logic                    rd_en,
  output logic                    rd_valid,
  output logic [DW-1:0]           rd_data,
  input  logic                    bus_wr_en,
  input  logic                    clr_drop,
  input  logic                    clr_wr_err,
  output logic                    drop_err,
  output logic                    wr_err
);

  logic             word_we;
  logic [DW-1:0]    word_data;
  logic             drop_pulse;
  logic [LVL_W-1:0] fill_level;

  rbf_loader #(
    .DEPTH     (DEPTH),
    .DW        (DW),
    .PKT_WORDS (PKT_WORDS)
  ) u_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid_i (pkt_valid),
    .pkt_ready_o (pkt_ready),
    .pkt_data_i  (pkt_data),
    .level_i     (fill_level),
    .we_o        (word_we),
    .wdata_o     (word_data),
    .drop_o      (drop_pulse)
  );

  rbf_storage #(
    .DEPTH (DEPTH),
    .DW    (DW)
  ) u_storage (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (word_we),
    .wdata_i    (word_data),
    .rd_en_i    (rd_en),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data),
    .level_o    (fill_level)
  );

  rbf_sticky u_drop_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (drop_pulse),
    .clr_i  (clr_drop),
    .flag_o (drop_err)
  );

  // Writes to the read window touch no storage; they only raise this flag.
  rbf_sticky u_wr_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (bus_wr_en),
    .clr_i  (clr_wr_err),
    .flag_o (wr_err)
  );

endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
  parameter int DEPTH     = 2048,
  parameter int DW        = 32,
  parameter int PKT_WORDS = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data,
  input logic             bus_wr_en,
  input logic             clr_drop,
  input logic             drop_err,
  input logic             wr_err,
  input logic [LVL_W-1:0] level
);

  localparam logic [LVL_W-1:0] ROOM_LIM = LVL_W'(DEPTH - PKT_WORDS);
  localparam logic [LVL_W-1:0] CAP      = LVL_W'(DEPTH);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && (level <= ROOM_LIM) |=> !pkt_ready);

  // R3
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R3
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R4
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (level == '0) |=> rd_valid && (rd_data == '0));

  // R5
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && (level > ROOM_LIM) |=> drop_err && pkt_ready);

  // R5
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && (level > ROOM_LIM) && !rd_en |=> level == $past(level));

  // R7
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err && !clr_drop |=> drop_err);

  // R8
  wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |=> wr_err);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP);

endmodule

bind rbf_top rbf_checker #(
  .DEPTH     (DEPTH),
  .DW        (DW),
  .PKT_WORDS (PKT_WORDS)
) u_rbf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .bus_wr_en (bus_wr_en),
  .clr_drop  (clr_drop),
  .drop_err  (drop_err),
  .wr_err    (wr_err),
  .level     (fill_level)
);

// File: tb/rbf_top_bench.sv
`timescale 1ns/1ps
module rbf_top_bench;

  localparam int DEPTH = 2048;
  localparam int DW    = 32;
  localparam int PW    = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pkt_valid = 1'b0;
  logic            pkt_ready;
  logic [PW*DW-1:0] pkt_data = '0;
  logic            rd_en = 1'b0;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;
  logic            bus_wr_en = 1'b0;
  logic            clr_drop = 1'b0;
  logic            clr_wr_err = 1'b0;
  logic            drop_err;
  logic            wr_err;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q [$];

  always #10 clk = ~clk;

  rbf_top u_rbf_top (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_wr_en(bus_wr_en), .clr_drop(clr_drop), .clr_wr_err(clr_wr_err),
    .drop_err(drop_err), .wr_err(wr_err)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Offer one packet; accept tells whether it must be stored.
  task automatic push_pkt(logic [DW-1:0] base, bit accept, string tag);
    while (!pkt_ready) tick();
    for (int w = 0; w < PW; w++) pkt_data[w*DW +: DW] = base + DW'(w);
    pkt_valid = 1'b1;
    tick();
    pkt_valid = 1'b0;
    if (accept) begin
      for (int w = 0; w < PW; w++) exp_q.push_back(base + DW'(w));
      for (int c = 0; c < 4; c++) begin
        if (c == 0) check({tag, " R2 busy after accept"}, DW'(pkt_ready), 0);
        tick();
        if (c != 3 && !pkt_ready) continue;
      end
      check({tag, " R2 ready after four cycles"}, DW'(pkt_ready), 1);
    end else begin
      check({tag, " R5 ready stays high on drop"}, DW'(pkt_ready), 1);
      check({tag, " R5 drop flag set"}, DW'(drop_err), 1);
    end
  endtask

  task automatic read_word(string tag);
    logic [DW-1:0] exp;
    exp = (exp_q.size() == 0) ? '0 : exp_q.pop_front();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    check({tag, " R3 rd_valid"}, DW'(rd_valid), 1);
    check({tag, " R3 data"}, rd_data, exp);
  endtask

  task automatic t_reset();
    check("R1 pkt_ready", DW'(pkt_ready), 1);
    check("R1 drop_err", DW'(drop_err), 0);
    check("R1 wr_err", DW'(wr_err), 0);
    check("R1 rd_valid", DW'(rd_valid), 0);
    read_word("R1 empty after reset");
    tick();
    check("R3 rd_valid idle low", DW'(rd_valid), 0);
  endtask

  task automatic t_basic();
    push_pkt(32'h1000_0000, 1'b1, "basic A");
    push_pkt(32'h2000_0000, 1'b1, "basic B");
    for (int i = 0; i < 8; i++) read_word("R2 basic order");
  endtask

  task automatic t_empty();
    read_word("R4 empty 1");
    read_word("R4 empty 2");
    push_pkt(32'h3000_0000, 1'b1, "R4 after empty");
    for (int i = 0; i < 4; i++) read_word("R4 order kept");
    read_word("R4 empty 3");
  endtask

  task automatic t_wr_window();
    push_pkt(32'h4000_0000, 1'b1, "R8 pkt");
    bus_wr_en = 1'b1;
    tick();
    bus_wr_en = 1'b0;
    check("R8 wr_err set", DW'(wr_err), 1);
    tick();
    check("R8 wr_err sticky", DW'(wr_err), 1);
    for (int i = 0; i < 4; i++) read_word("R8 data unchanged");
    read_word("R8 nothing extra stored");
    clr_wr_err = 1'b1;
    tick();
    clr_wr_err = 1'b0;
    check("R8 wr_err cleared", DW'(wr_err), 0);
  endtask

  task automatic t_concurrent();
    push_pkt(32'h5000_0000, 1'b1, "R9 A");
    while (!pkt_ready) tick();
    for (int w = 0; w < PW; w++) pkt_data[w*DW +: DW] = 32'h6000_0000 + DW'(w);
    pkt_valid = 1'b1;
    rd_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      tick();
      pkt_valid = 1'b0;
      check("R9 read during fill", rd_data, e);
    end
    rd_en = 1'b0;
    for (int w = 0; w < PW; w++) exp_q.push_back(32'h6000_0000 + DW'(w));
    tick();
    tick();
    for (int i = 0; i < 4; i++) read_word("R9 packet after fill");
    read_word("R9 empty afterwards");
  endtask

  task automatic t_full();
    for (int p = 0; p < DEPTH / PW; p++)
      push_pkt(32'hC000_0000 + DW'(p * 16), 1'b1, "R6 fill");
    push_pkt(32'hDEAD_0000, 1'b0, "R5 full");
    repeat (3) tick();
    check("R7 drop_err sticky", DW'(drop_err), 1);
    clr_drop = 1'b1;
    tick();
    clr_drop = 1'b0;
    check("R7 drop_err cleared", DW'(drop_err), 0);
    // Drop and clear in the same cycle: set wins.
    for (int w = 0; w < PW; w++) pkt_data[w*DW +: DW] = 32'hBAD0_0000;
    pkt_valid = 1'b1;
    clr_drop = 1'b1;
    tick();
    pkt_valid = 1'b0;
    clr_drop = 1'b0;
    check("R7 set beats clear", DW'(drop_err), 1);
    read_word("R6 first word");
    push_pkt(32'hBEEF_0000, 1'b0, "R5 one free");
    for (int i = 0; i < 3; i++) read_word("R6 pop to four free");
    push_pkt(32'hE000_0000, 1'b1, "R6 four free");
    for (int i = 0; i < DEPTH; i++) read_word("R6 drain");
    read_word("R5 no dropped words stored");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_empty();
    t_wr_window();
    t_concurrent();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule